// File: doc/BRIEF.md
# Page-Addressed Accumulator Processor Core

This block is a small 12-bit processor with one accumulator and one link bit. It runs memory-reference programs from an internal 4096-word by 12-bit store. Each instruction word packs four fields: a 3-bit operation code, an indirect flag, a page-select flag and a 7-bit offset. The memory is split into pages of 128 words. An operand address is either the offset within page zero or the offset within the page that holds the instruction being executed. One optional level of indirection lets a program reach any word of memory. There is no stack, so a subroutine call stores its return address in the first word of the routine it calls.

The environment fills memory through a load port while reset is held, supplies the start address and releases reset. It then waits for the halted flag and reads the results back through a separate read port. The accumulator, the link and the program counter are visible at all times. Each instruction takes a fetch cycle and an address cycle. Memory-reference operations take one further execute cycle.

Top module: `pgacc_core`

## Requirements
- R1: While `rst_n` is low, `acc` is 0, `link` is 0, `halted` is 0 and `pc` equals `start_pc`.
- R2: An instruction word holds the opcode in bits 11:9, the indirect flag in bit 8, the page select in bit 7 and the offset in bits 6:0. With page select 0 the direct address is the offset in page 0. With page select 1 it is the offset inside the page of the instruction's own address, even when that instruction is the last word of a page. Opcodes are AND=0, TAD=1, ISZ=2, DCA=3, JMS=4, JMP=5, IOT=6 and OPR=7.
- R3: With the indirect flag set, the word stored at the direct address is used as the full 12-bit operand address, and that pointer word is left unchanged.
- R4: TAD adds the operand to `acc` modulo 4096, and a carry out of bit 11 inverts `link`. No other instruction changes `link`.
- R5: AND replaces `acc` with the bitwise AND of `acc` and the operand.
- R6: DCA stores `acc` at the operand address and then clears `acc`.
- R7: JMP loads the operand address into `pc`.
- R8: JMS stores the address following the JMS at the operand address and continues at the operand address plus 1.
- R9: ISZ adds 1 modulo 4096 to the operand word and writes it back. When the new value is 0, the next instruction is skipped.
- R10: An OPR word with bit 8 clear and bit 7 set (for example 0xE80) clears `acc`. An OPR word with both bits clear (0xE00) has no effect. IOT words have no effect.
- R11: The word 0xF02 halts the core. `halted` goes to 1, `pc` holds the HLT address plus 1, and `pc`, `acc` and `link` then stay fixed until reset.
- R12: The program counter advances by one modulo 4096 on each fetch, so execution wraps from address 0xFFF to 0x000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_pc | input | 12 | Address loaded into the program counter during reset |
| load_we | input | 1 | Write strobe of the memory load port |
| load_addr | input | 12 | Load port address |
| load_data | input | 12 | Load port write data |
| peek_addr | input | 12 | Read port address |
| peek_data | output | 12 | Memory word at `peek_addr` (combinational) |
| halted | output | 1 | Set after a HLT instruction executes |
| acc | output | 12 | Accumulator |
| pc | output | 12 | Program counter |
| link | output | 1 | Link bit |

## Verification
A sweep of TAD over pairs of operands that include 0xFFF+1 catches a link that is set instead of inverted, and a sum that is not truncated. An instruction placed in the last word of a page catches a core that forms its current-page address from the incremented PC: such a core reads the decoy word in the next page. ISZ is run with a counter of 0xFFF and with a small counter. A core that skips on the wrong condition halts one word away from the expected address. JMS checks both the stored return word and the resume point, so an off-by-one in either shows up. Runs that start at 0xFFF and waits after a halt expose a PC that does not wrap or that keeps moving after the halt.

// File: rtl/pgacc_pkg.sv
package pgacc_pkg;

   typedef enum logic [2:0] {
      OP_AND = 3'd0,
      OP_TAD = 3'd1,
      OP_ISZ = 3'd2,
      OP_DCA = 3'd3,
      OP_JMS = 3'd4,
      OP_JMP = 3'd5,
      OP_IOT = 3'd6,
      OP_OPR = 3'd7
   } op_e;

   typedef enum logic [1:0] {
      ST_FETCH = 2'd0,
      ST_ADDR  = 2'd1,
      ST_EXEC  = 2'd2,
      ST_HALT  = 2'd3
   } st_e;

   localparam int OP_W = 3;

endpackage

// File: rtl/pgacc_ram.sv
module pgacc_ram #(
   parameter int W  = 12,
   parameter int AW = 12
) (
   input  logic          clk,
   input  logic [AW-1:0] core_addr,
   output logic [W-1:0]  core_rdata,
   input  logic          core_we,
   input  logic [W-1:0]  core_wdata,
   input  logic          ld_we,
   input  logic [AW-1:0] ld_addr,
   input  logic [W-1:0]  ld_wdata,
   input  logic [AW-1:0] rd_addr,
   output logic [W-1:0]  rd_data
);
   localparam int DEPTH = 1 << AW;

   logic [W-1:0] mem [DEPTH];

   // load port wins a same-cycle collision
   always_ff @(posedge clk) begin
      if (ld_we)
         mem[ld_addr] <= ld_wdata;
      else if (core_we)
         mem[core_addr] <= core_wdata;
   end

   assign core_rdata = mem[core_addr];
   assign rd_data    = mem[rd_addr];

endmodule

// File: rtl/pgacc_ea.sv
module pgacc_ea
   import pgacc_pkg::*;
#(
   parameter int W = 12
) (
   input  logic [W-1:0]      ir,
   input  logic [W-OP_W-3:0] ipage,
   output op_e               op,
   output logic              ind,
   output logic              cur,
   output logic [W-1:0]      daddr
);
   localparam int OFF_W  = W - OP_W - 2;
   localparam int PAGE_W = W - OFF_W;

   logic [OFF_W-1:0] off;

   assign op  = op_e'(ir[W-1 -: OP_W]);
   assign ind = ir[W-OP_W-1];
   assign cur = ir[W-OP_W-2];
   assign off = ir[OFF_W-1:0];

   // page bits come from the instruction's own page, never the advanced PC
   assign daddr = cur ? {ipage, off} : {{PAGE_W{1'b0}}, off};

endmodule

// File: rtl/pgacc_alu.sv
module pgacc_alu #(
   parameter int W = 12
) (
   input  logic [W-1:0] ac,
   input  logic [W-1:0] opnd,
   output logic [W-1:0] and_res,
   output logic [W-1:0] sum,
   output logic         carry,
   output logic [W-1:0] inc,
   output logic         inc_zero
);
   assign and_res      = ac & opnd;
   assign {carry, sum} = {1'b0, ac} + {1'b0, opnd};
   assign inc          = opnd + W'(1);
   assign inc_zero     = (inc == '0);

endmodule

// File: rtl/pgacc_core.sv
module pgacc_core
   import pgacc_pkg::*;
#(
   parameter int WORD_W = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [WORD_W-1:0] start_pc,
   input  logic              load_we,
   input  logic [WORD_W-1:0] load_addr,
   input  logic [WORD_W-1:0] load_data,
   input  logic [WORD_W-1:0] peek_addr,
   output logic [WORD_W-1:0] peek_data,
   output logic              halted,
   output logic [WORD_W-1:0] acc,
   output logic [WORD_W-1:0] pc,
   output logic              link
);
   localparam int OFF_W  = WORD_W - OP_W - 2;
   localparam int PAGE_W = WORD_W - OFF_W;
   localparam logic [WORD_W-1:0] HLT_WORD =
      WORD_W'((7 << (WORD_W - 3)) | (1 << (WORD_W - 4)) | 2);

   generate
      if (WORD_W < 8) begin : g_bad_width
         $error("pgacc_core: WORD_W must be at least 8");
      end
      if (PAGE_W < 1) begin : g_bad_page
         $error("pgacc_core: no page bits left");
      end
   endgenerate

   st_e               st;
   logic [WORD_W-1:0] ir;
   logic [PAGE_W-1:0] ipage;
   logic [WORD_W-1:0] ea;

   op_e               op;
   logic              ind;
   logic              cur;
   logic [WORD_W-1:0] daddr;

   logic [WORD_W-1:0] mem_addr;
   logic [WORD_W-1:0] mem_rdata;
   logic              mem_we;
   logic [WORD_W-1:0] mem_wdata;

   logic [WORD_W-1:0] and_res;
   logic [WORD_W-1:0] sum;
   logic              carry;
   logic [WORD_W-1:0] inc;
   logic              inc_zero;

   logic              is_cla;

   pgacc_ea #(.W(WORD_W)) u_ea (
      .ir    (ir),
      .ipage (ipage),
      .op    (op),
      .ind   (ind),
      .cur   (cur),
      .daddr (daddr)
   );

   pgacc_alu #(.W(WORD_W)) u_alu (
      .ac       (acc),
      .opnd     (mem_rdata),
      .and_res  (and_res),
      .sum      (sum),
      .carry    (carry),
      .inc      (inc),
      .inc_zero (inc_zero)
   );

   pgacc_ram #(.W(WORD_W), .AW(WORD_W)) u_ram (
      .clk        (clk),
      .core_addr  (mem_addr),
      .core_rdata (mem_rdata),
      .core_we    (mem_we),
      .core_wdata (mem_wdata),
      .ld_we      (load_we),
      .ld_addr    (load_addr),
      .ld_wdata   (load_data),
      .rd_addr    (peek_addr),
      .rd_data    (peek_data)
   );

   // group-one operate word with the clear-accumulator bit
   assign is_cla = ~ind & cur;

   always_comb begin
      unique case (st)
         ST_ADDR: mem_addr = daddr;
         ST_EXEC: mem_addr = ea;
         default: mem_addr = pc;
      endcase
   end

   always_comb begin
      mem_we    = 1'b0;
      mem_wdata = pc;
      if (st == ST_EXEC) begin
         unique case (op)
            OP_DCA:  begin mem_we = 1'b1; mem_wdata = acc; end
            OP_ISZ:  begin mem_we = 1'b1; mem_wdata = inc; end
            OP_JMS:  begin mem_we = 1'b1; mem_wdata = pc;  end
            default: mem_we = 1'b0;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st     <= ST_FETCH;
         pc     <= start_pc;
         acc    <= '0;
         link   <= 1'b0;
         halted <= 1'b0;
         ir     <= '0;
         ipage  <= '0;
         ea     <= '0;
      end else begin
         unique case (st)
            ST_FETCH: begin
               ir    <= mem_rdata;
               ipage <= pc[WORD_W-1:OFF_W];
               pc    <= pc + WORD_W'(1);
               st    <= ST_ADDR;
            end
            ST_ADDR: begin
               if (op == OP_OPR) begin
                  if (ir == HLT_WORD) begin
                     halted <= 1'b1;
                     st     <= ST_HALT;
                  end else begin
                     if (is_cla)
                        acc <= '0;
                     st <= ST_FETCH;
                  end
               end else if (op == OP_IOT) begin
                  st <= ST_FETCH;
               end else begin
                  ea <= ind ? mem_rdata : daddr;
                  st <= ST_EXEC;
               end
            end
            ST_EXEC: begin
               unique case (op)
                  OP_AND: acc <= and_res;
                  OP_TAD: begin
                     acc  <= sum;
                     link <= link ^ carry;
                  end
                  OP_ISZ: if (inc_zero) pc <= pc + WORD_W'(1);
                  OP_DCA: acc <= '0;
                  OP_JMS: pc  <= ea + WORD_W'(1);
                  OP_JMP: pc  <= ea;
                  default: ;
               endcase
               st <= ST_FETCH;
            end
            default: st <= ST_HALT;
         endcase
      end
   end

endmodule

// File: rtl/pgacc_chk.sv
module pgacc_chk
   import pgacc_pkg::*;
#(
   parameter int W = 12
) (
   input logic         clk,
   input logic         rst_n,
   input st_e          st,
   input op_e          op,
   input logic         ind,
   input logic         cur,
   input logic [W-1:0] ea,
   input logic [W-1:0] pc,
   input logic [W-1:0] acc,
   input logic         link,
   input logic         halted
);
   localparam int OFF_W = W - OP_W - 2;

   logic exec_now;
   assign exec_now = (st == ST_EXEC);

   AST_ZERO_PAGE_EA: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_ADDR && op < OP_IOT && !ind && !cur) |=> ea[W-1:OFF_W] == '0); // R2

   AST_LINK_TAD_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      !(exec_now && op == OP_TAD) |=> $stable(link)); // R4

   AST_AND_NO_NEW_ONES: assert property (@(posedge clk) disable iff (!rst_n)
      (exec_now && op == OP_AND) |=> (acc & ~$past(acc)) == '0); // R5

   AST_DCA_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (exec_now && op == OP_DCA) |=> acc == '0); // R6

   AST_JMP_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
      (exec_now && op == OP_JMP) |=> pc == $past(ea)); // R7

   AST_JMS_RESUME: assert property (@(posedge clk) disable iff (!rst_n)
      (exec_now && op == OP_JMS) |=> pc == W'($past(ea) + W'(1))); // R8

   AST_HALT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      halted |=> halted && $stable(pc) && $stable(acc) && $stable(link)); // R11

   AST_FETCH_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_FETCH) |=> pc == W'($past(pc) + W'(1))); // R12

endmodule

bind pgacc_core pgacc_chk #(.W(WORD_W)) u_chk (
   .clk    (clk),
   .rst_n  (rst_n),
   .st     (st),
   .op     (op),
   .ind    (ind),
   .cur    (cur),
   .ea     (ea),
   .pc     (pc),
   .acc    (acc),
   .link   (link),
   .halted (halted)
);

// File: tb/pgacc_core_tb.sv
module pgacc_core_tb;

   // clock period 4 time units: 250 MHz
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [11:0] start_pc = '0;
   logic        load_we = 1'b0;
   logic [11:0] load_addr = '0;
   logic [11:0] load_data = '0;
   logic [11:0] peek_addr = '0;
   logic [11:0] peek_data;
   logic        halted;
   logic [11:0] acc;
   logic [11:0] pc;
   logic        link;

   int checks = 0;
   int errors = 0;

   localparam logic [11:0] P    = 12'h080;
   localparam logic [11:0] HLT  = 12'hF02;
   localparam logic [11:0] NOP  = 12'hE00;
   localparam logic [11:0] CLA  = 12'hE80;
   localparam logic [11:0] IOTW = 12'hC00;

   always #2 clk = ~clk;

   pgacc_core u_dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .start_pc  (start_pc),
      .load_we   (load_we),
      .load_addr (load_addr),
      .load_data (load_data),
      .peek_addr (peek_addr),
      .peek_data (peek_data),
      .halted    (halted),
      .acc       (acc),
      .pc        (pc),
      .link      (link)
   );

   function automatic logic [11:0] mk(int op, int i, int z, int off);
      return 12'((op << 9) | (i << 8) | (z << 7) | (off & 127));
   endfunction

   task automatic chk(string req, string what, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
      end
   endtask

   task automatic prep(logic [11:0] s);
      @(negedge clk);
      rst_n    = 1'b0;
      start_pc = s;
      load_we  = 1'b0;
   endtask

   task automatic poke(logic [11:0] a, logic [11:0] d);
      @(negedge clk);
      load_we   = 1'b1;
      load_addr = a;
      load_data = d;
   endtask

   task automatic go(string req);
      @(negedge clk);
      load_we = 1'b0;
      rst_n   = 1'b1;
      for (int n = 0; n < 400; n++) begin
         @(negedge clk);
         if (halted) break;
      end
      if (!halted) chk(req, "halt reached", 0, 1);
   endtask

   task automatic peek(logic [11:0] a, output logic [11:0] d);
      peek_addr = a;
      #1;
      d = peek_data;
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL R11 watchdog halted act=0 exp=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      logic [11:0] d;
      int a, b, s, p0, a0;

      // R1: reset state
      @(negedge clk);
      start_pc = 12'h123;
      @(negedge clk);
      chk("R1", "acc", acc, 0);
      chk("R1", "link", link, 0);
      chk("R1", "halted", halted, 0);
      chk("R1", "pc", pc, 12'h123);

      // R4 R6: TAD pair sweep, result stored by DCA
      for (int i = 0; i < 32; i++) begin
         for (int j = 0; j < 32; j++) begin
            a = (i == 31) ? 4095 : (i * 131) & 4095;
            b = (j == 31) ? 1 : (j * 257 + 3) & 4095;
            prep(P);
            poke(P + 0, mk(1, 0, 1, 8'h40));
            poke(P + 1, mk(1, 0, 1, 8'h41));
            poke(P + 2, mk(3, 0, 1, 8'h42));
            poke(P + 3, HLT);
            poke(P + 12'h40, 12'(a));
            poke(P + 12'h41, 12'(b));
            go("R4");
            s = a + b;
            peek(P + 12'h42, d);
            chk("R4", "sum", d, s & 4095);
            chk("R4", "link", link, (s >> 12) & 1);
            chk("R6", "acc after DCA", acc, 0);
         end
      end

      // R4: link left set, then R1 reset clears it
      prep(P);
      poke(P + 0, mk(1, 0, 1, 8'h40));
      poke(P + 1, mk(1, 0, 1, 8'h41));
      poke(P + 2, mk(1, 0, 1, 8'h42));
      poke(P + 3, HLT);
      poke(P + 12'h40, 12'hFFF);
      poke(P + 12'h41, 12'h001);
      poke(P + 12'h42, 12'h005);
      go("R4");
      chk("R4", "acc", acc, 5);
      chk("R4", "link one carry", link, 1);
      @(negedge clk);
      start_pc = 12'h3A5;
      rst_n = 1'b0;
      @(negedge clk);
      chk("R1", "acc after reset", acc, 0);
      chk("R1", "link after reset", link, 0);
      chk("R1", "halted after reset", halted, 0);
      chk("R1", "pc after reset", pc, 12'h3A5);

      // R4: two carries invert the link twice
      prep(P);
      poke(P + 3, mk(1, 0, 1, 8'h40));
      poke(P + 4, mk(1, 0, 1, 8'h41));
      poke(P + 5, HLT);
      poke(P + 0, mk(1, 0, 1, 8'h40));
      poke(P + 1, mk(1, 0, 1, 8'h41));
      poke(P + 2, NOP);
      go("R4");
      chk("R4", "link after two carries", link, 0);
      chk("R4", "acc after two carries", acc, 0);

      // R5: AND sweep
      for (int i = 0; i < 16; i++) begin
         for (int j = 0; j < 16; j++) begin
            a = (i * 273 + 5) & 4095;
            b = (j == 15) ? 4095 : (j * 397 + 11) & 4095;
            prep(P);
            poke(P + 0, mk(1, 0, 1, 8'h40));
            poke(P + 1, mk(0, 0, 1, 8'h41));
            poke(P + 2, HLT);
            poke(P + 12'h40, 12'(a));
            poke(P + 12'h41, 12'(b));
            go("R5");
            chk("R5", "and", acc, a & b);
            chk("R5", "link untouched", link, 0);
         end
      end

      // R2: zero page versus current page
      for (int z = 0; z < 2; z++) begin
         prep(P);
         poke(12'h005, 12'h123);
         poke(P + 12'h05, 12'h456);
         poke(P + 0, mk(1, 0, z, 5));
         poke(P + 1, HLT);
         go("R2");
         chk("R2", z ? "current page" : "zero page", acc, z ? 12'h456 : 12'h123);
      end

      // R2: instruction in the last word of a page uses its own page
      prep(12'h0FF);
      poke(12'h0FF, mk(1, 0, 1, 8'h10));
      poke(12'h090, 12'h321);
      poke(12'h110, 12'h777);
      poke(12'h100, HLT);
      go("R2");
      chk("R2", "page end operand", acc, 12'h321);
      chk("R12", "pc after page end", pc, 12'h101);

      // R3 R6: indirect reads and an indirect store
      prep(P);
      poke(12'h010, 12'hABC);
      poke(12'hABC, 12'h0F0);
      poke(P + 12'h40, 12'h5A5);
      poke(12'h5A5, 12'h000);
      poke(P + 0, mk(1, 1, 0, 8'h10));
      poke(P + 1, mk(1, 1, 0, 8'h10));
      poke(P + 2, mk(3, 1, 1, 8'h40));
      poke(P + 3, HLT);
      go("R3");
      peek(12'h5A5, d);
      chk("R3", "indirect store", d, 12'h1E0);
      peek(P + 12'h40, d);
      chk("R3", "pointer unchanged", d, 12'h5A5);
      peek(12'h010, d);
      chk("R3", "zero page pointer unchanged", d, 12'hABC);
      chk("R6", "acc cleared", acc, 0);

      // R7: direct and indirect jumps
      prep(P);
      poke(P + 0, mk(5, 0, 1, 8'h20));
      poke(P + 1, HLT);
      poke(P + 12'h20, HLT);
      go("R7");
      chk("R7", "direct jump", pc, P + 12'h21);
      prep(P);
      poke(12'h011, 12'hC40);
      poke(12'hC40, HLT);
      poke(P + 0, mk(5, 1, 0, 8'h11));
      poke(P + 1, HLT);
      go("R7");
      chk("R7", "indirect jump", pc, 12'hC41);

      // R8: subroutine call
      prep(P);
      poke(P + 0, NOP);
      poke(P + 1, NOP);
      poke(P + 2, mk(4, 0, 1, 8'h30));
      poke(P + 3, HLT);
      poke(P + 12'h30, 12'h000);
      poke(P + 12'h31, HLT);
      go("R8");
      peek(P + 12'h30, d);
      chk("R8", "return word", d, P + 3);
      chk("R8", "resume point", pc, P + 12'h32);

      // R9: ISZ with wrap to zero and with a plain increment
      for (int k = 0; k < 2; k++) begin
         a0 = k ? 5 : 4095;
         prep(P);
         poke(P + 12'h40, 12'(a0));
         poke(P + 0, mk(2, 0, 1, 8'h40));
         poke(P + 1, HLT);
         poke(P + 2, HLT);
         go("R9");
         peek(P + 12'h40, d);
         chk("R9", "counter", d, (a0 + 1) & 4095);
         p0 = k ? P + 2 : P + 3;
         chk("R9", k ? "no skip" : "skip", pc, p0);
      end

      // R10: IOT and plain OPR keep acc, CLA clears it
      prep(P);
      poke(P + 12'h40, 12'h321);
      poke(P + 0, mk(1, 0, 1, 8'h40));
      poke(P + 1, IOTW);
      poke(P + 2, NOP);
      poke(P + 3, HLT);
      go("R10");
      chk("R10", "iot and nop keep acc", acc, 12'h321);
      prep(P);
      poke(P + 12'h40, 12'h321);
      poke(P + 0, mk(1, 0, 1, 8'h40));
      poke(P + 1, CLA);
      poke(P + 2, HLT);
      go("R10");
      chk("R10", "cla", acc, 0);

      // R11: halt freezes pc and acc
      prep(P);
      poke(P + 12'h40, 12'h0AB);
      poke(P + 0, mk(1, 0, 1, 8'h40));
      poke(P + 1, HLT);
      poke(P + 2, mk(1, 0, 1, 8'h40));
      go("R11");
      chk("R11", "pc at halt", pc, P + 2);
      repeat (20) @(negedge clk);
      chk("R11", "halted held", halted, 1);
      chk("R11", "pc frozen", pc, P + 2);
      chk("R11", "acc frozen", acc, 12'h0AB);

      // R12: fetch wraps past the top of memory
      prep(12'hFFF);
      poke(12'hFFF, NOP);
      poke(12'h000, HLT);
      go("R12");
      chk("R12", "pc wrap", pc, 12'h001);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule